// File: doc/BRIEF.md
# Synchronous Constant-Current Chopper Controller (Winding Pair)

This block is the digital side of a fixed-frequency, constant-current chopper for one motor phase and its complementary half. A free-running divider produces one strobe per PWM period. At every strobe, the half that is currently selected has its gate latched on. The gate is latched off again when that half's current comparator reports that the reference has been reached. For a short blanking interval after each turn-on, the comparator is not looked at, so that the switching spike cannot end the on-time early. Once the gate is off, it stays off until the next strobe.

A single period divider clocks both halves. Every winding driven from the same strobe therefore chops in step, and holding a motor still makes no beat between phases. The step sequencer chooses a half with a one-bit command. When that command changes, both gates are held off for a programmable dead interval, and the newly chosen half begins at the next period start. A low enable cuts both gates at once. The comparators, the reference DAC and the power stage sit outside the block.

The PWM period, the blanking length and the dead interval are all parameters counted in system-clock cycles.

Top module: `chop_pair_ctrl`

## Requirements
- R1: `period_stb` is a single-cycle pulse. It first goes high in cycle PERIOD_CYC after reset release (the first cycle with `rst_n` high is cycle 0), and then every PERIOD_CYC cycles, whatever `enable`, `phase_cmd` or the trips are doing.
- R2: If the selected half is allowed (enabled, no dead interval pending) in a strobe cycle, its gate is high from the next cycle on.
- R3: The comparator is ignored for the first BLANK_CYC cycles of each on-interval. If the trip is already active when the gate turns on, the gate stays high for exactly BLANK_CYC+1 cycles.
- R4: A trip seen in cycle t after blanking has ended drives the gate low from cycle t+1. The gate stays low until the cycle after the next strobe, even if the trip goes away. With the trip raised in the k-th cycle after turn-on (k counted from 0), the on-time is max(k, BLANK_CYC)+1 cycles.
- R5: `phase_cmd`=1 selects `gate_p`, which is chopped by `trip_p`. `phase_cmd`=0 selects `gate_n`, which is chopped by `trip_n`. The unselected gate stays low, and the two gates are never high together.
- R6: When `phase_cmd` changes in cycle m, both gates are low from m+1 through m+DEAD_CYC. The newly selected half turns on in the cycle after the first strobe at or after cycle m+DEAD_CYC+1. A strobe that falls inside the dead interval is skipped.
- R7: When `enable` is low, both gates are low in that same cycle. After `enable` returns high, they stay low until the cycle after the next strobe.
- R8: A synchronous active-low reset clears both gates and the strobe. It leaves `gate_p` as the selected half with no dead interval pending; a `phase_cmd` of 0 at release counts as a change under R6. No gate goes high before the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Output enable; low forces both gates off |
| phase_cmd | input | 1 | Selected half from the sequencer: 1 = true side, 0 = complement |
| trip_p | input | 1 | Comparator for the true side; high when current has reached the reference |
| trip_n | input | 1 | Comparator for the complement side |
| gate_p | output | 1 | Gate drive, true side |
| gate_n | output | 1 | Gate drive, complement side |
| period_stb | output | 1 | One-cycle pulse at the start of each PWM period |

## Verification
The bench builds the block with a 20-cycle period, 3 blanking cycles and a 4-cycle dead interval. These values are small enough that many whole periods fit in a short run. They let trips be placed before, exactly at and after the end of blanking, and they make a trip that never releases fill almost a whole period. With them, a strobe can be made to land two cycles into a dead interval, which reaches the skipped-strobe case of R6. A phase change just after a strobe reaches the opposite case, where the dead interval runs out well before the next period starts.

// File: rtl/chop_pkg.sv
// Shared helpers for the chopper controller.
// Assumes every count handed to cnt_bits is zero or positive.
package chop_pkg;

    // Bit positions of the two halves in the per-side vectors.
    localparam int SIDE_N = 0;
    localparam int SIDE_P = 1;

    // Width of a counter that must hold values 0..max_val.
    function automatic int cnt_bits(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/chop_period_timer.sv
// Free-running PWM period divider shared by every winding.
// Produces a one-cycle strobe each PERIOD_CYC cycles. The first strobe
// comes PERIOD_CYC cycles after reset release.
// Assumes PERIOD_CYC >= 2.
module chop_period_timer #(
    parameter int PERIOD_CYC = 2720
) (
    input  logic clk,
    input  logic rst_n,
    output logic period_stb
);
    localparam int CW = chop_pkg::cnt_bits(PERIOD_CYC - 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Count through one period and wrap to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    // Register the wrap as the period-start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) period_stb <= 1'b0;
        else        period_stb <= (cnt_q == LAST);
    end

    // Independent spacing monitor for the strobe.
    localparam int GW = chop_pkg::cnt_bits(PERIOD_CYC);
    logic [GW-1:0] gap_q;
    logic          seen_q;

    // Count cycles since reset or since the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (period_stb) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != GW'(PERIOD_CYC)) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    assert_stb_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        period_stb |-> (gap_q == (seen_q ? GW'(PERIOD_CYC - 1) : GW'(PERIOD_CYC))));

    assert_stb_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        period_stb |=> !period_stb);

endmodule

// File: rtl/chop_latch_cell.sv
// Set-reset gate latch for one half-winding, with blanking after turn-on.
// A set request latches the gate on and starts the blanking count. A trip
// after blanking clears the latch. Loss of allow clears it at once.
// Assumes set_req is only raised while allow is high.
module chop_latch_cell #(
    parameter int BLANK_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic allow,
    input  logic trip,
    output logic gate
);
    localparam int BW = chop_pkg::cnt_bits(BLANK_CYC);
    localparam logic [BW-1:0] BLANK_LD = BW'(BLANK_CYC);

    logic          on_q;
    logic [BW-1:0] blank_q;

    // Latch state: cut, set, count down blanking, or trip off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q    <= 1'b0;
            blank_q <= '0;
        end else if (!allow) begin
            on_q    <= 1'b0;
            blank_q <= '0;
        end else if (set_req) begin
            on_q    <= 1'b1;
            blank_q <= BLANK_LD;
        end else if (on_q && (blank_q != '0)) begin
            blank_q <= blank_q - 1'b1;
        end else if (on_q && trip) begin
            on_q    <= 1'b0;
        end
    end

    // Gate follows the latch, cut immediately when not allowed.
    always_comb gate = on_q & allow;

    assert_blank_masks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (on_q && (blank_q != '0) && allow) |=> on_q);

    assert_trip_cuts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (on_q && (blank_q == '0) && trip && !set_req) |=> !on_q);

    assert_stays_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_q && !set_req) |=> !on_q);

endmodule

// File: rtl/chop_deadtime_guard.sv
// Selects which half may conduct and enforces the dead interval.
// A change of phase_cmd blocks both halves for DEAD_CYC cycles. Enable
// acts combinationally, so a low enable cuts both halves in the same cycle.
// Assumes phase_cmd is synchronous to clk.
module chop_deadtime_guard #(
    parameter int DEAD_CYC = 469
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       phase_cmd,
    output logic [1:0] allow
);
    localparam int DW = chop_pkg::cnt_bits(DEAD_CYC);
    localparam logic [DW-1:0] DEAD_LD = DW'(DEAD_CYC);

    logic          cmd_q;
    logic [DW-1:0] dead_q;

    // Track the accepted selection and run the dead interval after a change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= 1'b1;
            dead_q <= '0;
        end else if (phase_cmd != cmd_q) begin
            cmd_q  <= phase_cmd;
            dead_q <= DEAD_LD;
        end else if (dead_q != '0) begin
            dead_q <= dead_q - 1'b1;
        end
    end

    // Permission per half.
    always_comb begin
        allow[chop_pkg::SIDE_P] = enable &  cmd_q & (dead_q == '0);
        allow[chop_pkg::SIDE_N] = enable & ~cmd_q & (dead_q == '0);
    end

    if (DEAD_CYC > 0) begin : g_dead_chk
        assert_switch_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (phase_cmd != cmd_q) |=> (allow == 2'b00));
    end

endmodule

// File: rtl/chop_pair_ctrl.sv
// Constant-current chopper controller for a phase and its complement.
// One shared period timer strobes both latch cells. The dead-time guard
// decides which cell may be set. Comparator inputs are assumed synchronous.
module chop_pair_ctrl #(
    parameter int PERIOD_CYC = 2720,
    parameter int BLANK_CYC  = 125,
    parameter int DEAD_CYC   = 469
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic phase_cmd,
    input  logic trip_p,
    input  logic trip_n,
    output logic gate_p,
    output logic gate_n,
    output logic period_stb
);
    logic [1:0] allow;
    logic [1:0] trips;
    logic [1:0] gates;

    assign trips[chop_pkg::SIDE_P] = trip_p;
    assign trips[chop_pkg::SIDE_N] = trip_n;

    chop_period_timer #(.PERIOD_CYC(PERIOD_CYC)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_stb (period_stb)
    );

    chop_deadtime_guard #(.DEAD_CYC(DEAD_CYC)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .phase_cmd (phase_cmd),
        .allow     (allow)
    );

    for (genvar s = 0; s < 2; s++) begin : g_side
        chop_latch_cell #(.BLANK_CYC(BLANK_CYC)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (period_stb & allow[s]),
            .allow   (allow[s]),
            .trip    (trips[s]),
            .gate    (gates[s])
        );
    end

    assign gate_p = gates[chop_pkg::SIDE_P];
    assign gate_n = gates[chop_pkg::SIDE_N];

    // Monitor of the off gap between the two gates.
    localparam int IW = chop_pkg::cnt_bits(DEAD_CYC);
    logic [IW-1:0] idle_q;
    logic [1:0]    last_q;

    // Count consecutive cycles with both gates low, saturating at DEAD_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n)                           idle_q <= '0;
        else if (gate_p || gate_n)            idle_q <= '0;
        else if (idle_q != IW'(DEAD_CYC))     idle_q <= idle_q + 1'b1;
    end

    // Remember which gate conducted most recently.
    always_ff @(posedge clk) begin
        if (!rst_n)      last_q <= 2'b00;
        else if (gate_p) last_q <= 2'b10;
        else if (gate_n) last_q <= 2'b01;
    end

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_p && gate_n));

    assert_gap_p_to_n_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_n) && last_q[1]) |-> (idle_q >= IW'(DEAD_CYC)));

    assert_gap_n_to_p_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_p) && last_q[0]) |-> (idle_q >= IW'(DEAD_CYC)));

    assert_enable_cuts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!gate_p && !gate_n));

endmodule

// File: tb/tb_chop_pair_ctrl.sv
// Bench: a vector table walked per PWM period, then directed reset,
// trip-release, dead-time and enable tests.
module tb_chop_pair_ctrl;
    localparam int P = 20;
    localparam int B = 3;
    localparam int D = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic phase_cmd = 1'b1;
    logic trip_p = 1'b0;
    logic trip_n = 1'b0;
    logic gate_p, gate_n, period_stb;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    chop_pair_ctrl #(.PERIOD_CYC(P), .BLANK_CYC(B), .DEAD_CYC(D)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .phase_cmd(phase_cmd),
        .trip_p(trip_p), .trip_n(trip_n),
        .gate_p(gate_p), .gate_n(gate_n), .period_stb(period_stb)
    );

    // Each entry: {phase_cmd, enable, trip offset k, expected on-cycles}
    localparam logic [11:0] VEC [0:9] = '{
        {1'b1, 1'b1, 5'd0,  5'd4},
        {1'b1, 1'b1, 5'd3,  5'd4},
        {1'b1, 1'b1, 5'd4,  5'd5},
        {1'b1, 1'b1, 5'd10, 5'd11},
        {1'b0, 1'b1, 5'd0,  5'd4},
        {1'b0, 1'b1, 5'd7,  5'd8},
        {1'b0, 1'b1, 5'd18, 5'd19},
        {1'b1, 1'b0, 5'd5,  5'd0},
        {1'b1, 1'b1, 5'd18, 5'd19},
        {1'b0, 1'b1, 5'd2,  5'd4}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Advance to the drive point of the next cycle.
    task automatic next_cycle();
        @(posedge clk);
        #2;
    endtask

    // Step cycles until period_stb is seen at the sample point.
    task automatic sync_stb();
        for (int g = 0; g < 4 * P; g++) begin
            next_cycle();
            #3;
            if (period_stb) return;
        end
        chk("R1", "strobe not found", 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int first;
        int cnt;
        int other;
        int any_p;
        logic ph, en;
        int k, expl;

        // R8: reset state
        repeat (3) next_cycle();
        #3;
        chk("R8", "gate_p in reset", int'(gate_p), 0);
        chk("R8", "gate_n in reset", int'(gate_n), 0);
        chk("R8", "period_stb in reset", int'(period_stb), 0);

        // R1 / R8: first strobe after release, no gate before it
        next_cycle();
        rst_n = 1'b1;
        first = -1;
        any_p = 0;
        for (int j = 0; j <= P; j++) begin
            if (j > 0) next_cycle();
            #3;
            if (period_stb && first < 0) first = j;
            if (gate_p || gate_n) any_p = 1;
        end
        chk("R1", "first strobe cycle", first, P);
        chk("R8", "gate before first strobe", any_p, 0);
        next_cycle();
        #3;
        chk("R2", "gate_p after first strobe", int'(gate_p), 1);
        chk("R1", "strobe width", int'(period_stb), 0);
        cnt = 1;
        for (int j = 0; j < 3 * P; j++) begin
            next_cycle();
            #3;
            cnt++;
            if (period_stb) break;
        end
        chk("R1", "strobe spacing", cnt, P);

        // Table walk: one PWM period per entry
        for (int i = 0; i < 10; i++) begin
            {ph, en} = VEC[i][11:10];
            k = int'(VEC[i][9:5]);
            expl = int'(VEC[i][4:0]);
            next_cycle();
            phase_cmd = ph;
            enable = en;
            trip_p = 1'b0;
            trip_n = 1'b0;
            repeat (D + 2) next_cycle();
            sync_stb();
            cnt = 0;
            first = 0;
            other = 0;
            for (int j = 1; j < P; j++) begin
                next_cycle();
                if (j - 1 >= k) begin
                    if (ph) trip_p = 1'b1;
                    else    trip_n = 1'b1;
                end
                #3;
                if (j == 1) first = int'(ph ? gate_p : gate_n);
                cnt += int'(ph ? gate_p : gate_n);
                other |= int'(ph ? gate_n : gate_p);
            end
            if (en) begin
                chk("R3/R4", $sformatf("vec %0d on-cycles", i), cnt, expl);
                chk("R2", $sformatf("vec %0d turn-on after strobe", i), first, (expl > 0) ? 1 : 0);
                chk("R5", $sformatf("vec %0d unselected gate", i), other, 0);
            end else begin
                chk("R7", $sformatf("vec %0d disabled selected gate", i), cnt, 0);
                chk("R7", $sformatf("vec %0d disabled other gate", i), other, 0);
            end
        end

        // R4: one-cycle trip after blanking, gate stays off after release
        next_cycle();
        trip_p = 1'b0;
        trip_n = 1'b0;
        phase_cmd = 1'b1;
        enable = 1'b1;
        repeat (D + 2) next_cycle();
        sync_stb();
        cnt = 0;
        first = 0;
        for (int j = 1; j < P; j++) begin
            next_cycle();
            trip_p = (j == 7);
            #3;
            cnt += int'(gate_p);
            if (j == P - 1) first = int'(gate_p);
        end
        chk("R4", "on-cycles with released trip", cnt, 7);
        chk("R4", "gate still off at period end", first, 0);

        // R6: change with a strobe inside the dead interval
        trip_p = 1'b0;
        sync_stb();
        repeat (P - 2) next_cycle();
        phase_cmd = 1'b0;
        first = -1;
        any_p = 0;
        other = 0;
        for (int j = 1; j <= P + 3; j++) begin
            next_cycle();
            #3;
            if (gate_n && first < 0) first = j;
            if (gate_p) any_p = 1;
            if (j <= D && (gate_p || gate_n)) other = 1;
        end
        chk("R6", "both low during dead interval", other, 0);
        chk("R6", "old side gate_p off after change", any_p, 0);
        chk("R6", "gate_n first on (strobe in dead skipped)", first, P + 3);

        // R6: change right after a strobe, dead ends before next strobe
        sync_stb();
        next_cycle();
        phase_cmd = 1'b1;
        first = -1;
        other = 0;
        for (int j = 1; j <= P; j++) begin
            next_cycle();
            #3;
            if (gate_p && first < 0) first = j;
            if (gate_n) other = 1;
        end
        chk("R6", "gate_n off after change", other, 0);
        chk("R6", "gate_p first on after dead", first, P);

        // R7: enable drop mid on-time
        sync_stb();
        next_cycle();
        next_cycle();
        enable = 1'b0;
        #3;
        chk("R7", "gate_p cut same cycle", int'(gate_p), 0);
        next_cycle();
        enable = 1'b1;
        #3;
        chk("R7", "gate_p off after re-enable", int'(gate_p), 0);
        any_p = 0;
        for (int j = 4; j <= P; j++) begin
            next_cycle();
            #3;
            if (gate_p) any_p = 1;
        end
        chk("R7", "gate_p stays off until strobe", any_p, 0);
        next_cycle();
        #3;
        chk("R2", "gate_p on after strobe following re-enable", int'(gate_p), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule